// File: doc/BRIEF.md
# Credit-Based Transmit Flow Gate

This block sits on the sending end of a point-to-point link. It decides, cycle by cycle, whether the packet waiting at its request port may be sent now. The receiving side gives the sender credits. The gate first takes a starting allowance from an advertisement. It adds each granted packet's cost to a consumed-credit counter. It raises its credit limit whenever the receiver returns credit. Both counters are free-running and wrap. Admission uses a modular difference rather than an absolute compare, so the gate stays correct for any number of packets.

A requester presents one packet at a time, with its cost, and holds it until it is granted. The grant is combinational from registered state, so a packet that fits goes out in the cycle it is presented. Credit returns only ever add allowance, so their latency never holds up a packet while enough credit remains. An advertisement of zero puts the gate into an unmetered mode in which every request is granted.

Top module: `credit_tx_gate`

## Requirements
- R1: After reset, and until the first advertisement, `req_grant`, `headroom` and `unlimited` are 0. Credit updates that arrive in this state are ignored.
- R2: An advertisement loads the limit with `adv_credits` and clears the consumed count, so `headroom` equals `adv_credits` in the next cycle. No request is granted in the advertisement cycle.
- R3: In metered mode, `req_grant` is high in the same cycle as `req_valid` exactly when (limit − (consumed + `req_cost`)) mod 256 is at most 128. Given R5's bounds, this is the same as `req_cost` ≤ `headroom`, including an exact fit.
- R4: A granted request in metered mode lowers `headroom` by `req_cost` in the next cycle.
- R5: In metered mode, a credit update raises `headroom` by `upd_credits` in the next cycle. The sender keeps `req_cost` below 128, and the receiver keeps `headroom` at or below 128.
- R6: A grant and a credit update in the same cycle both take effect: the next `headroom` is `headroom` − `req_cost` + `upd_credits`.
- R7: Admission stays correct after the consumed and limit counters wrap past 255, for any number of wraps.
- R8: A zero advertisement sets `unlimited` to 1. Every request is then granted, `headroom` reads 0, and credit updates are ignored.
- R9: A request that does not fit stays ungranted while it is held. It is granted in the first cycle after credit updates make it fit, and in no earlier cycle.
- R10: An advertisement during operation reloads the gate, replacing the old limit and consumed count, and moves it between metered and unmetered mode as the new value dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_valid | input | 1 | Initial credit advertisement strobe |
| adv_credits | input | 8 | Advertised allowance; 0 selects unmetered mode |
| upd_valid | input | 1 | Credit-return strobe |
| upd_credits | input | 8 | Credits restored by the receiver |
| req_valid | input | 1 | A packet is waiting to be sent |
| req_cost | input | 8 | Credit cost of the waiting packet (below 128) |
| req_grant | output | 1 | Packet may be sent this cycle |
| headroom | output | 8 | Limit minus consumed, modulo 256; 0 when not metered |
| unlimited | output | 1 | Gate is in unmetered mode |

## Verification
The bench builds the gate with its default counter width of 8 bits. This keeps the wrap of both counters within a few dozen grants, and it makes the half-range boundary of 128 reachable directly as a full-headroom case. Long alternating and same-cycle grant/update runs push the consumed count around the ring several times while the expected headroom is tracked. An exact fit at zero remaining credit, a one-credit shortfall, and a packet stalled until a return arrives cover the edges of the admission rule.

// File: rtl/credit_gate_pkg.sv
// Shared types for the credit transmit gate.
// Assumes nothing beyond being compiled before the modules that import it.
package credit_gate_pkg;

    // Operating mode of the gate.
    typedef enum logic [1:0] {
        GM_WAIT   = 2'd0,  // no advertisement seen yet
        GM_FINITE = 2'd1,  // metered by credit limit
        GM_OPEN   = 2'd2   // zero advertised: unmetered
    } gate_mode_e;

endpackage

// File: rtl/cg_mode_ctrl.sv
// Mode register of the credit gate.
// What it does: leaves the wait state on the first advertisement and picks
// metered or unmetered mode from whether the advertised value is zero.
// Assumes: adv_zero is only meaningful while adv_valid is high.
module cg_mode_ctrl
    import credit_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_valid,
    input  logic       adv_zero,
    output gate_mode_e mode
);

    // Purpose: track the operating mode, reloaded on every advertisement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= GM_WAIT;
        end else if (adv_valid) begin
            mode <= adv_zero ? GM_OPEN : GM_FINITE;
        end
    end

endmodule

// File: rtl/cg_counter.sv
// Free-running modular accumulator used for both the credit limit and the
// consumed-credit count.
// What it does: loads a value, or adds an increment, wrapping modulo 2^W.
// Assumes: load wins over add in the same cycle.
module cg_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] count
);

    // Purpose: hold the wrapping count, with reload taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (add_en) begin
            count <= count + add_val;
        end
    end

endmodule

// File: rtl/cg_admit.sv
// Admission decision of the credit gate.
// What it does: grants the waiting packet when the modular distance from
// (consumed + cost) up to the limit is within half the counter range, or
// at once in unmetered mode.
// Assumes: cost stays below half the range and the outstanding allowance
// never exceeds half the range, so the modular test equals a plain one.
module cg_admit
    import credit_gate_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  gate_mode_e   mode,
    input  logic         adv_valid,
    input  logic         req_valid,
    input  logic [W-1:0] req_cost,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] consumed,
    output logic         grant
);

    localparam logic [W-1:0] HALF_RANGE = W'(1) << (W - 1);

    logic [W-1:0] after_send;
    logic [W-1:0] slack;
    logic         fits;

    // Purpose: wrap-safe comparison of the projected consumption to the limit.
    always_comb begin
        after_send = consumed + req_cost;
        slack      = limit - after_send;
        fits       = (slack <= HALF_RANGE);
    end

    // Purpose: combine the mode with the fit test into the grant.
    always_comb begin
        grant = 1'b0;
        if (req_valid && !adv_valid) begin
            case (mode)
                GM_FINITE: grant = fits;
                GM_OPEN:   grant = 1'b1;
                default:   grant = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/credit_tx_gate.sv
// Credit-based transmit flow gate (top).
// What it does: loads a credit limit from an advertisement, counts credits
// consumed by granted packets, raises the limit on credit returns, and
// grants the waiting packet only when it fits under the limit.
// Assumes: the requester holds req_valid and req_cost until granted,
// req_cost < 2^(W-1), and returns never lift headroom above 2^(W-1).
module credit_tx_gate
    import credit_gate_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_valid,
    input  logic [CNT_W-1:0] adv_credits,
    input  logic             upd_valid,
    input  logic [CNT_W-1:0] upd_credits,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_cost,
    output logic             req_grant,
    output logic [CNT_W-1:0] headroom,
    output logic             unlimited
);

    localparam logic [CNT_W-1:0] HALF_RANGE = CNT_W'(1) << (CNT_W - 1);

    gate_mode_e       mode;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] consumed_q;
    logic             adv_zero;
    logic             metered;
    logic             limit_add;
    logic             consume_add;

    // Purpose: decode the mode and the counter enables.
    always_comb begin
        adv_zero    = (adv_credits == '0);
        metered     = (mode == GM_FINITE);
        limit_add   = upd_valid && metered;
        consume_add = req_grant && metered;
    end

    cg_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_valid (adv_valid),
        .adv_zero  (adv_zero),
        .mode      (mode)
    );

    cg_counter #(.W(CNT_W)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (adv_valid),
        .load_val (adv_credits),
        .add_en   (limit_add),
        .add_val  (upd_credits),
        .count    (limit_q)
    );

    cg_counter #(.W(CNT_W)) u_consumed (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (adv_valid),
        .load_val ('0),
        .add_en   (consume_add),
        .add_val  (req_cost),
        .count    (consumed_q)
    );

    cg_admit #(.W(CNT_W)) u_admit (
        .mode      (mode),
        .adv_valid (adv_valid),
        .req_valid (req_valid),
        .req_cost  (req_cost),
        .limit     (limit_q),
        .consumed  (consumed_q),
        .grant     (req_grant)
    );

    // Purpose: present remaining allowance and mode flag.
    always_comb begin
        headroom  = metered ? (limit_q - consumed_q) : '0;
        unlimited = (mode == GM_OPEN);
    end

    // R1: nothing is granted before the first advertisement
    a_r1_no_grant_before_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_WAIT) |-> !req_grant);

    // R2: advertisement sets headroom to the advertised value
    a_r2_adv_loads: assert property (@(posedge clk) disable iff (!rst_n)
        adv_valid |=> (headroom == $past(adv_credits)) || unlimited);

    // R3: a metered grant never exceeds the remaining allowance
    a_r3_grant_within: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && metered) |-> (req_cost <= headroom));

    // R4: a lone grant lowers headroom by its cost
    a_r4_grant_spends: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && metered && !upd_valid && !adv_valid)
        |=> headroom == $past(headroom - req_cost));

    // R5: a lone update raises headroom by the returned amount
    a_r5_update_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && metered && !req_grant && !adv_valid)
        |=> headroom == $past(headroom + upd_credits));

    // R5: allowance stays within half the range
    a_r5_headroom_bound: assert property (@(posedge clk) disable iff (!rst_n)
        metered |-> (headroom <= HALF_RANGE));

    // R6: grant and update in one cycle are both applied
    a_r6_both_applied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && upd_valid && metered && !adv_valid)
        |=> headroom == $past(headroom - req_cost + upd_credits));

    // R8: unmetered mode grants every request
    a_r8_open_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (unlimited && req_valid && !adv_valid) |-> req_grant);

endmodule

// File: tb/credit_tx_gate_test.sv
`timescale 1ns/100ps
module credit_tx_gate_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_valid = 1'b0;
    logic [7:0] adv_credits = '0;
    logic       upd_valid = 1'b0;
    logic [7:0] upd_credits = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_cost = '0;
    logic       req_grant;
    logic [7:0] headroom;
    logic       unlimited;

    always #2.5 clk = ~clk;

    credit_tx_gate #(.CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .adv_valid(adv_valid), .adv_credits(adv_credits),
        .upd_valid(upd_valid), .upd_credits(upd_credits),
        .req_valid(req_valid), .req_cost(req_cost),
        .req_grant(req_grant), .headroom(headroom), .unlimited(unlimited)
    );

    typedef struct {
        logic       grant;
        logic [7:0] room;
        logic       unl;
        string      tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   fails = 0;

    // Reference state kept from the requirements.
    bit       m_ready = 0;
    bit       m_unl = 0;
    bit [7:0] m_lim = 0;
    bit [7:0] m_con = 0;

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input bit av, input bit [7:0] an, input bit rv,
                        input bit [7:0] rc, input bit uv, input bit [7:0] un,
                        input string tag);
        exp_t e;
        bit   fit;
        bit   g;
        @(negedge clk);
        adv_valid = av; adv_credits = an;
        req_valid = rv; req_cost = rc;
        upd_valid = uv; upd_credits = un;
        fit = (8'(m_lim - 8'(m_con + rc)) <= 8'd128);
        g   = rv && !av && m_ready && (m_unl || fit);
        e.grant = g;
        e.room  = (m_ready && !m_unl) ? 8'(m_lim - m_con) : 8'd0;
        e.unl   = m_ready && m_unl;
        e.tag   = tag;
        expq.push_back(e);
        @(posedge clk);
        if (av) begin
            m_ready = 1; m_unl = (an == 0); m_lim = an; m_con = 0;
        end else if (m_ready && !m_unl) begin
            if (g)  m_con = 8'(m_con + rc);
            if (uv) m_lim = 8'(m_lim + un);
        end
    endtask

    // Monitor: compare outputs against queued expectations away from the edge.
    always @(negedge clk) begin
        #1;
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if (req_grant !== e.grant || headroom !== e.room || unlimited !== e.unl) begin
                fails++;
                $display("FAIL %s: grant/headroom/unlimited = %0b/%0d/%0b expected %0b/%0d/%0b",
                         e.tag, req_grant, headroom, unlimited, e.grant, e.room, e.unl);
            end
        end
    end

    bit done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state seen at the ports while reset is held
        @(negedge clk); req_valid = 1; req_cost = 8'd1;
        #1;
        checks++;
        if (req_grant !== 0 || headroom !== 0 || unlimited !== 0) begin
            fails++;
            $display("FAIL R1: reset grant/headroom/unlimited = %0b/%0d/%0b expected 0/0/0",
                     req_grant, headroom, unlimited);
        end
        @(negedge clk); rst_n = 1;

        // R1: requests and updates before any advertisement
        step(0, 0, 1, 8'd1, 0, 0, "R1");
        step(0, 0, 1, 8'd1, 1, 8'd40, "R1");
        step(0, 0, 1, 8'd1, 0, 0, "R1");

        // R2: advertise 10 with a request present
        step(1, 8'd10, 1, 8'd3, 0, 0, "R2");
        // R3/R4: three grants of 3
        step(0, 0, 1, 8'd3, 0, 0, "R3");
        step(0, 0, 1, 8'd3, 0, 0, "R4");
        step(0, 0, 1, 8'd3, 0, 0, "R4");
        // R9: cost 2 against 1 left, held until a return
        step(0, 0, 1, 8'd2, 0, 0, "R9");
        step(0, 0, 1, 8'd2, 0, 0, "R9");
        step(0, 0, 1, 8'd2, 1, 8'd1, "R9");
        step(0, 0, 1, 8'd2, 0, 0, "R9");
        // R5: lone update
        step(0, 0, 0, 0, 1, 8'd20, "R5");
        // R6: grant and update together
        step(0, 0, 1, 8'd5, 1, 8'd7, "R6");
        // R3: exact fit then one-credit shortfall
        step(0, 0, 1, 8'd22, 0, 0, "R3");
        step(0, 0, 1, 8'd1, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 8'd10, "R5");

        // R7: many wraps via alternating and simultaneous traffic
        for (int i = 0; i < 40; i++) begin
            step(0, 0, 1, 8'd10, 0, 0, "R7");
            step(0, 0, 0, 0, 1, 8'd10, "R7");
        end
        for (int i = 0; i < 30; i++) begin
            step(0, 0, 1, 8'd9, 1, 8'd9, "R7");
        end
        step(0, 0, 1, 8'd11, 0, 0, "R7");

        // R10: reload to 50 and spend it all
        step(1, 8'd50, 0, 0, 0, 0, "R10");
        step(0, 0, 1, 8'd50, 0, 0, "R10");
        step(0, 0, 1, 8'd1, 0, 0, "R10");
        // R5: fill to the 128 bound and spend 127
        step(0, 0, 0, 0, 1, 8'd128, "R5");
        step(0, 0, 1, 8'd127, 0, 0, "R3");
        step(0, 0, 1, 8'd2, 0, 0, "R3");

        // R8: unmetered mode
        step(1, 8'd0, 1, 8'd100, 0, 0, "R8");
        step(0, 0, 1, 8'd100, 0, 0, "R8");
        step(0, 0, 1, 8'd127, 1, 8'd30, "R8");
        step(0, 0, 1, 8'd5, 0, 0, "R8");
        // R10: back to metered from unmetered
        step(1, 8'd5, 1, 8'd6, 0, 0, "R10");
        step(0, 0, 1, 8'd6, 0, 0, "R10");
        step(0, 0, 1, 8'd5, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");

        @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule